// File: doc/BRIEF.md
# Configurable Split / Double-Buffered Endpoint Packet FIFO

This block is the byte-wide packet store behind one endpoint of a serial-bus device controller. It holds a single storage array of `DEPTH` bytes. Two inputs set how that array is used. The array can serve as one unified FIFO. It can also be cut into two equal halves: an IN half, where the bus side produces and the endpoint consumes, and an OUT half, where the endpoint produces and the bus side consumes. Each active FIFO can also run as one full-size packet slot, or as two half-size slots used in ping-pong order. With two slots, one packet can be drained while the next is being filled.

The bus side sees one data register. A write strobe loads one byte and a read strobe unloads one byte. The layout decides which FIFO each strobe reaches. Every producer closes a packet with a commit strobe, and every consumer frees a drained packet with a release strobe. Single-cycle flags report a rejected write or a read that found nothing. Any change to the layout inputs empties the whole block. The usual sizes are 128, 256 or 512 bytes, and a fixed 64-byte instance is this block with split and double buffering held low.

Top module: `ep_pktbuf`

## Requirements
- R1: After reset, `bus_rdata` and `ep_rdata` are 0x00, all four flags are 0, and every FIFO is empty. A consume strobe on an active FIFO reports underflow.
- R2: With `cfg_split`=1, the IN FIFO occupies addresses 0 to DEPTH/2-1 and takes `bus_wr` bytes, which `ep_pop` drains. The OUT FIFO occupies DEPTH/2 to DEPTH-1 and takes `ep_push` bytes, which `bus_rd` drains. Both may move a byte in the same cycle without disturbing each other.
- R3: With `cfg_split`=0, all DEPTH bytes form one FIFO. With `cfg_out_dir`=0 it runs bus-to-endpoint, and with `cfg_out_dir`=1 it runs endpoint-to-bus. Strobes of the idle direction are ignored and raise no flag.
- R4: Each accepted consume strobe returns exactly one byte, registered and visible the cycle after the strobe. Bytes come out in write order. A committed packet yields only as many bytes as were written into it.
- R5: A slot holds the region size in single-buffer mode and half of it in double-buffer mode. The region is DEPTH when unified and DEPTH/2 when split. A write beyond the slot size, or into a committed slot, is dropped, and the matching overflow flag (`bus_ovf` or `ep_ovf`) is 1 in the following cycle.
- R6: A consume strobe that finds no committed data, or finds the packet already drained, returns 0x00 and sets the matching underflow flag (`ep_unf` or `bus_unf`) in the following cycle.
- R7: In double-buffer mode, the producer can fill and commit a second packet while the first is still resident or being drained. Once both slots are committed, further writes are dropped as in R5. Packets leave in commit order.
- R8: In split mode, `cfg_dbuf_in` sets double buffering for the IN FIFO and `cfg_dbuf_out` sets it for the OUT FIFO, each on its own. In unified mode, `cfg_dbuf_in` alone applies to the whole FIFO.
- R9: A release frees the current packet's slot even if it is only partly drained, and its remaining bytes are discarded. A release with no committed packet has no effect. A commit with zero bytes written forms an empty packet, which reads as underflow.
- R10: Any change on `cfg_split`, `cfg_out_dir`, `cfg_dbuf_in` or `cfg_dbuf_out` clears every count, pointer and packet. Strobes presented in the cycle of the change are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_split | input | 1 | 1: separate IN and OUT halves |
| cfg_out_dir | input | 1 | Unified direction: 0 bus-to-endpoint, 1 endpoint-to-bus |
| cfg_dbuf_in | input | 1 | Double buffering for IN (or for the unified FIFO) |
| cfg_dbuf_out | input | 1 | Double buffering for OUT in split mode |
| bus_wr | input | 1 | Data register write strobe |
| bus_wdata | input | 8 | Data register write byte |
| bus_commit | input | 1 | Bus-side packet commit |
| bus_rd | input | 1 | Data register read strobe |
| bus_release | input | 1 | Bus-side packet release |
| bus_rdata | output | 8 | Data register read byte |
| bus_ovf | output | 1 | Bus write was dropped |
| bus_unf | output | 1 | Bus read found no data |
| ep_push | input | 1 | Endpoint byte push |
| ep_wdata | input | 8 | Endpoint push byte |
| ep_commit | input | 1 | Endpoint packet commit |
| ep_pop | input | 1 | Endpoint byte pop |
| ep_release | input | 1 | Endpoint packet release |
| ep_rdata | output | 8 | Endpoint pop byte |
| ep_ovf | output | 1 | Endpoint push was dropped |
| ep_unf | output | 1 | Endpoint pop found no data |

## Verification
Two pairs of operations can land in the same clock edge. In split mode, a bus write into the IN half and an endpoint push into the OUT half can coincide, and both reach the shared array through separate write ports. In double-buffer mode, the producer can fill or commit one slot in the same cycle that the consumer drains or releases the other. The bench drives both strobes of each pair in one cycle. Every byte read back must equal the arithmetically predicted value for its direction, packet and position, and no spurious flag may appear. An exhaustive sweep over all sixteen layouts of a 16-byte instance checks slot sizes, overflow and underflow edges against sizes computed from the layout bits.

// File: rtl/ep_pktbuf.sv
module ep_pktbuf #(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_split,
  input  logic          cfg_out_dir,
  input  logic          cfg_dbuf_in,
  input  logic          cfg_dbuf_out,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_commit,
  input  logic          bus_rd,
  input  logic          bus_release,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ovf,
  output logic          bus_unf,
  input  logic          ep_push,
  input  logic [DW-1:0] ep_wdata,
  input  logic          ep_commit,
  input  logic          ep_pop,
  input  logic          ep_release,
  output logic [DW-1:0] ep_rdata,
  output logic          ep_ovf,
  output logic          ep_unf
);

  localparam int AW = $clog2(DEPTH);
  localparam int HALF = DEPTH / 2;
  localparam logic [AW:0] ONE = (AW+1)'(1);

  // channel 0 = IN (bus produces), channel 1 = OUT (endpoint produces)
  logic [DW-1:0] mem [DEPTH];

  logic [3:0] cfg_now, cfg_q;
  logic       flush;
  assign cfg_now = {cfg_split, cfg_out_dir, cfg_dbuf_in, cfg_dbuf_out};
  assign flush   = cfg_now != cfg_q;

  logic          act   [2];
  logic          dbl   [2];
  logic [AW:0]   ssize [2];
  logic [AW-1:0] base  [2];

  logic          pwr  [2];
  logic          pcm  [2];
  logic          crd  [2];
  logic          crl  [2];
  logic [DW-1:0] pdat [2];

  assign pwr[0]  = bus_wr;
  assign pwr[1]  = ep_push;
  assign pcm[0]  = bus_commit;
  assign pcm[1]  = ep_commit;
  assign crd[0]  = ep_pop;
  assign crd[1]  = bus_rd;
  assign crl[0]  = ep_release;
  assign crl[1]  = bus_release;
  assign pdat[0] = bus_wdata;
  assign pdat[1] = ep_wdata;

  logic [AW:0] cnt  [2][2];
  logic        cmt  [2][2];
  logic        wsl  [2];
  logic        rsl  [2];
  logic [AW:0] roff [2];

  logic          wr_ok [2];
  logic          rd_ok [2];
  logic          cm_ok [2];
  logic          rl_ok [2];
  logic          ovf   [2];
  logic          unf   [2];
  logic [AW-1:0] waddr [2];
  logic [AW-1:0] raddr [2];

  logic [DW-1:0] rdq   [2];
  logic          ovf_q [2];
  logic          unf_q [2];

  logic [AW:0] region;
  assign region = cfg_split ? (AW+1)'(HALF) : (AW+1)'(DEPTH);

  always_comb begin
    act[0]  = cfg_split | ~cfg_out_dir;
    act[1]  = cfg_split |  cfg_out_dir;
    dbl[0]  = cfg_dbuf_in;
    dbl[1]  = cfg_split ? cfg_dbuf_out : cfg_dbuf_in;
    base[0] = '0;
    base[1] = cfg_split ? AW'(HALF) : '0;
    for (int c = 0; c < 2; c++) begin
      ssize[c] = region >> dbl[c];
    end
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      wr_ok[c] = !flush && act[c] && pwr[c] && !cmt[c][wsl[c]]
                 && (cnt[c][wsl[c]] < ssize[c]);
      ovf[c]   = !flush && act[c] && pwr[c] && !wr_ok[c];
      rd_ok[c] = !flush && act[c] && crd[c] && cmt[c][rsl[c]]
                 && (roff[c] < cnt[c][rsl[c]]);
      unf[c]   = !flush && act[c] && crd[c] && !rd_ok[c];
      cm_ok[c] = !flush && act[c] && pcm[c] && !cmt[c][wsl[c]];
      rl_ok[c] = !flush && act[c] && crl[c] && cmt[c][rsl[c]];
      waddr[c] = base[c] + (wsl[c] ? ssize[c][AW-1:0] : '0)
                 + cnt[c][wsl[c]][AW-1:0];
      raddr[c] = base[c] + (rsl[c] ? ssize[c][AW-1:0] : '0)
                 + roff[c][AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (wr_ok[c]) mem[waddr[c]] <= pdat[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      for (int c = 0; c < 2; c++) begin
        wsl[c]   <= 1'b0;
        rsl[c]   <= 1'b0;
        roff[c]  <= '0;
        rdq[c]   <= '0;
        ovf_q[c] <= 1'b0;
        unf_q[c] <= 1'b0;
        for (int s = 0; s < 2; s++) begin
          cnt[c][s] <= '0;
          cmt[c][s] <= 1'b0;
        end
      end
    end else begin
      cfg_q <= cfg_now;
      for (int c = 0; c < 2; c++) begin
        ovf_q[c] <= ovf[c];
        unf_q[c] <= unf[c];
        if (flush) begin
          wsl[c]  <= 1'b0;
          rsl[c]  <= 1'b0;
          roff[c] <= '0;
          for (int s = 0; s < 2; s++) begin
            cnt[c][s] <= '0;
            cmt[c][s] <= 1'b0;
          end
        end else begin
          if (act[c] && crd[c])
            rdq[c] <= rd_ok[c] ? mem[raddr[c]] : '0;
          if (rl_ok[c]) begin
            cmt[c][rsl[c]] <= 1'b0;
            cnt[c][rsl[c]] <= '0;
            roff[c]        <= '0;
            if (dbl[c]) rsl[c] <= ~rsl[c];
          end else if (rd_ok[c]) begin
            roff[c] <= roff[c] + ONE;
          end
          if (wr_ok[c]) cnt[c][wsl[c]] <= cnt[c][wsl[c]] + ONE;
          if (cm_ok[c]) begin
            cmt[c][wsl[c]] <= 1'b1;
            if (dbl[c]) wsl[c] <= ~wsl[c];
          end
        end
      end
    end
  end

  assign ep_rdata  = rdq[0];
  assign bus_rdata = rdq[1];
  assign bus_ovf   = ovf_q[0];
  assign ep_ovf    = ovf_q[1];
  assign ep_unf    = unf_q[0];
  assign bus_unf   = unf_q[1];

  for (genvar g = 0; g < 2; g++) begin : g_chk
    a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ok[g] && !rl_ok[g] |=> roff[g] == $past(roff[g]) + ONE);
    a_r4_drain_limit: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |-> roff[g] <= cnt[g][rsl[g]]);
    a_r5_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |-> cnt[g][0] <= ssize[g] && cnt[g][1] <= ssize[g]);
    a_r5_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[g] && !rl_ok[g] |=> $stable(cnt[g][0]) && $stable(cnt[g][1]));
    a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      unf[g] |=> rdq[g] == '0 && unf_q[g]);
    a_r7_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
      !flush && !dbl[g] |-> !wsl[g] && !rsl[g]);
    a_r10_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> cnt[g][0] == '0 && cnt[g][1] == '0 && !cmt[g][0]
                && !cmt[g][1] && roff[g] == '0);
  end

endmodule

// File: tb/ep_pktbuf_tb_top.sv
module ep_pktbuf_tb_top;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_split = 0, cfg_out_dir = 0, cfg_dbuf_in = 0, cfg_dbuf_out = 0;
  logic bus_wr = 0, bus_commit = 0, bus_rd = 0, bus_release = 0;
  logic ep_push = 0, ep_commit = 0, ep_pop = 0, ep_release = 0;
  logic [7:0] bus_wdata = 0, ep_wdata = 0;
  logic [7:0] bus_rdata, ep_rdata;
  logic bus_ovf, bus_unf, ep_ovf, ep_unf;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ep_pktbuf #(.DEPTH(DEPTH), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_split(cfg_split), .cfg_out_dir(cfg_out_dir),
    .cfg_dbuf_in(cfg_dbuf_in), .cfg_dbuf_out(cfg_dbuf_out),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_commit(bus_commit),
    .bus_rd(bus_rd), .bus_release(bus_release), .bus_rdata(bus_rdata),
    .bus_ovf(bus_ovf), .bus_unf(bus_unf),
    .ep_push(ep_push), .ep_wdata(ep_wdata), .ep_commit(ep_commit),
    .ep_pop(ep_pop), .ep_release(ep_release), .ep_rdata(ep_rdata),
    .ep_ovf(ep_ovf), .ep_unf(ep_unf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    bus_wr = 0; bus_commit = 0; bus_rd = 0; bus_release = 0;
    ep_push = 0; ep_commit = 0; ep_pop = 0; ep_release = 0;
  endtask

  task automatic setcfg(input logic [3:0] k);
    {cfg_split, cfg_out_dir, cfg_dbuf_in, cfg_dbuf_out} = k;
    tick();
  endtask

  task automatic produce(input int c, input logic [7:0] d, output logic f);
    if (c == 0) begin bus_wr = 1; bus_wdata = d; end
    else begin ep_push = 1; ep_wdata = d; end
    tick();
    f = (c == 0) ? bus_ovf : ep_ovf;
  endtask

  task automatic consume(input int c, output logic [7:0] d, output logic f);
    if (c == 0) ep_pop = 1; else bus_rd = 1;
    tick();
    d = (c == 0) ? ep_rdata : bus_rdata;
    f = (c == 0) ? ep_unf : bus_unf;
  endtask

  task automatic commit(input int c);
    if (c == 0) bus_commit = 1; else ep_commit = 1;
    tick();
  endtask

  task automatic release_pkt(input int c);
    if (c == 0) ep_release = 1; else bus_release = 1;
    tick();
  endtask

  function automatic logic [7:0] pat(input int k, input int c, input int p, input int i);
    return 8'((k << 4) ^ (c << 7) ^ (p << 3) ^ i);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got %0h expected %0h", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic f;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(bus_rdata == 0 && ep_rdata == 0, "R1 data after reset", {bus_rdata, ep_rdata}, 0);
    chk({bus_ovf, bus_unf, ep_ovf, ep_unf} == 0, "R1 flags after reset",
        {bus_ovf, bus_unf, ep_ovf, ep_unf}, 0);
    consume(0, d, f);
    chk(f == 1 && d == 0, "R1 empty after reset", {f, d}, 9'h100);

    // sweep every layout
    for (int k = 0; k < 16; k++) begin
      logic sp, dir, dbi, dbo;
      {sp, dir, dbi, dbo} = 4'(k);
      setcfg(4'(k));
      for (int c = 0; c < 2; c++) begin
        bit act, dbl;
        int ss, ns, len;
        string rq;
        act = sp || ((c == 0) ? !dir : dir);
        if (!act) begin
          produce(c, 8'hAA, f);
          chk(f == 0, "R3 idle write no flag", f, 0);
          consume(c, d, f);
          chk(f == 0, "R3 idle read no flag", f, 0);
          continue;
        end
        dbl = (c == 0) ? dbi : (sp ? dbo : dbi);
        ss  = (sp ? DEPTH / 2 : DEPTH) / (dbl ? 2 : 1);
        ns  = dbl ? 2 : 1;
        rq  = sp ? "R8 split slot size" : "R5 slot size";
        for (int p = 0; p < ns; p++) begin
          len = ss - p;
          for (int i = 0; i < len; i++) begin
            produce(c, pat(k, c, p, i), f);
            chk(f == 0, rq, f, 0);
          end
          if (p == 0) begin
            produce(c, 8'h5A, f);
            chk(f == 1, "R5 overflow past slot", f, 1);
          end
          commit(c);
        end
        produce(c, 8'hA5, f);
        chk(f == 1, "R7 all slots committed", f, 1);
        for (int p = 0; p < ns; p++) begin
          len = ss - p;
          for (int i = 0; i < len; i++) begin
            consume(c, d, f);
            chk(d == pat(k, c, p, i) && f == 0, sp ? "R2 data" : "R3 unified data",
                d, pat(k, c, p, i));
          end
          consume(c, d, f);
          chk(d == 0 && f == 1, "R4 drained packet stops", {f, d}, 9'h100);
          release_pkt(c);
        end
        consume(c, d, f);
        chk(d == 0 && f == 1, "R6 empty read", {f, d}, 9'h100);
      end
    end

    // R2 concurrent writes and reads in split mode
    setcfg(4'b1011);
    for (int i = 0; i < 4; i++) begin
      bus_wr = 1; bus_wdata = 8'(8'h10 + i);
      ep_push = 1; ep_wdata = 8'(8'h80 + i);
      tick();
      chk(bus_ovf == 0 && ep_ovf == 0, "R2 dual write accepted", {bus_ovf, ep_ovf}, 0);
    end
    bus_commit = 1; ep_commit = 1; tick();
    for (int i = 0; i < 4; i++) begin
      bus_rd = 1; ep_pop = 1; tick();
      chk(bus_rdata == 8'(8'h80 + i), "R2 OUT byte", bus_rdata, 8'h80 + i);
      chk(ep_rdata == 8'(8'h10 + i), "R2 IN byte", ep_rdata, 8'h10 + i);
    end
    bus_release = 1; ep_release = 1; tick();

    // R7 fill slot B while draining slot A
    for (int i = 0; i < 2; i++) begin
      produce(1, 8'(8'h31 + i), f);
    end
    commit(1);
    for (int i = 0; i < 2; i++) begin
      ep_push = 1; ep_wdata = 8'(8'h41 + i); bus_rd = 1; tick();
      chk(bus_rdata == 8'(8'h31 + i) && ep_ovf == 0, "R7 overlap drain",
          bus_rdata, 8'h31 + i);
    end
    ep_commit = 1; bus_release = 1; tick();
    for (int i = 0; i < 2; i++) begin
      consume(1, d, f);
      chk(d == 8'(8'h41 + i) && f == 0, "R7 second packet", d, 8'h41 + i);
    end
    release_pkt(1);

    // R9 release before drain, empty release, zero-length packet
    setcfg(4'b1000);
    for (int i = 0; i < 3; i++) produce(1, 8'(8'h51 + i), f);
    commit(1);
    consume(1, d, f);
    chk(d == 8'h51, "R9 first byte", d, 8'h51);
    release_pkt(1);
    produce(1, 8'h61, f);
    produce(1, 8'h62, f);
    commit(1);
    consume(1, d, f);
    chk(d == 8'h61 && f == 0, "R9 rest discarded", d, 8'h61);
    release_pkt(1);
    release_pkt(1);
    produce(1, 8'h71, f);
    chk(f == 0, "R9 empty release harmless", f, 0);
    commit(1);
    consume(1, d, f);
    chk(d == 8'h71, "R9 packet after empty release", d, 8'h71);
    release_pkt(1);
    commit(1);
    consume(1, d, f);
    chk(d == 0 && f == 1, "R9 zero-length packet", {f, d}, 9'h100);
    release_pkt(1);
    produce(1, 8'h72, f);
    chk(f == 0, "R9 slot freed after empty packet", f, 0);

    // R10 configuration change flushes
    commit(1);
    cfg_dbuf_in = 1; ep_push = 1; ep_wdata = 8'h91; tick();
    consume(1, d, f);
    chk(d == 0 && f == 1, "R10 packet flushed", {f, d}, 9'h100);
    commit(1);
    consume(1, d, f);
    chk(d == 0 && f == 1, "R10 strobe in change cycle ignored", {f, d}, 9'h100);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule